// File: doc/BRIEF.md
# Masked Associative Search Array

This block is a small content-addressable store. Each entry holds a data word and a valid bit. A comparand register is searched against every valid entry at once. The block keeps two mask registers, and a command picks which one is active. A bit set to 1 in the active mask makes that bit position a don't-care in the search. The same mask also protects bits from being overwritten by a masked write. When several entries hit, a priority encoder keeps only the lowest numbered one. A status word then reports that address, a page value, and the hit, multi-hit and full flags.

Software drives the block through a single synchronous command port: an opcode, an entry address and a data word, qualified by a valid strobe. A search runs without being asked whenever the comparand, either mask or the page register is written. It can also be forced by a command, and its result is registered into the status word one clock later. A combinational read port returns an entry or one of the registers. A second output gives the lowest free entry, which the fill-next-free command uses to store the comparand without an explicit address.

Top module: `masked_cam`

## Requirements
- R1: A bit set to 1 in the active mask is excluded from the comparison of the comparand against every entry.
- R2: Only entries whose valid bit is 1 can hit. Opcode 7 clears the valid bit of entry `cmd_addr`, and opcode 12 clears every valid bit.
- R3: When entries hit, the reported address is the lowest numbered hitting entry. When nothing hits, the address field is 0.
- R4: Status bit 1 (hit) is 1 when at least one valid entry matches. Status bit 2 (multi-hit) is 1 when two or more match.
- R5: A search is started by any of these opcodes: 1 (write comparand), 2 (write mask one), 3 (write mask two), 4 (write page register from `cmd_data[15:0]`) and 8 (forced search). The status word loads on the clock edge after the one that accepts the command. At all other times it holds its value.
- R6: The status word is {page[15:0], address[5:0], multi-hit, hit, full}, with full in bit 0. The page field is the page register value at the time of the search.
- R7: Opcode 5 writes `cmd_data` into entry `cmd_addr` and sets its valid bit. Every bit that is 1 in the active mask keeps its old value.
- R8: Opcode 9 shifts mask two one bit left and opcode 10 shifts it one bit right. The vacated bit is filled with 0, and neither opcode starts a search.
- R9: Opcode 11 selects mask two when `cmd_data[0]` is 1 and mask one when it is 0. Mask one is selected after reset, and the selection does not start a search.
- R10: `next_free` gives the lowest numbered entry whose valid bit is 0, and gives 0 when every entry is valid. The status full flag is 1 when no entry is free at the time of the search.
- R11: Opcode 6 writes the comparand into the `next_free` entry under the active mask and sets its valid bit. It has no effect when every entry is valid.
- R12: After reset the status word, all entries, all valid bits, the comparand, both masks and the page register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | 6 | Entry address for write and invalidate |
| cmd_data | input | 32 | Data word for register and entry writes |
| rd_sel | input | 2 | Read source: 0 entry, 1 comparand, 2 mask one, 3 mask two |
| rd_addr | input | 6 | Entry address for the read port |
| rd_data | output | 32 | Read data, combinational |
| rd_valid | output | 1 | Valid bit of entry `rd_addr` |
| next_free | output | 6 | Lowest free entry |
| status | output | 25 | Registered search result |

## Verification
The search is run against a fixed set of entries under several conditions. The first is an exact comparand with two identical entries, which separates the multi-hit case from the single-hit case. Next, one of those entries is invalidated, which shows whether valid bits gate hits. A low-half mask brings in entries that differ only in the upper bits, and a one-bit mask on mask two, shifted left and right, decides whether an entry differing only in bit 0 hits. The array is then filled through the next-free path, which exercises the full flag, the command being ignored when full, and the encoder choosing a high address after one entry is freed.

// File: rtl/cam_pkg.sv
// Package: shared opcodes for the masked search array.
// Assumes a 4-bit opcode field; unused codes act as no-ops.
package cam_pkg;
    typedef enum logic [3:0] {
        OP_NOP       = 4'd0,
        OP_WR_CMP    = 4'd1,
        OP_WR_MASK1  = 4'd2,
        OP_WR_MASK2  = 4'd3,
        OP_WR_PAGE   = 4'd4,
        OP_WR_MEM    = 4'd5,
        OP_FILL_FREE = 4'd6,
        OP_INVAL     = 4'd7,
        OP_SEARCH    = 4'd8,
        OP_SHL_MASK2 = 4'd9,
        OP_SHR_MASK2 = 4'd10,
        OP_SEL_MASK  = 4'd11,
        OP_CLR_VALID = 4'd12
    } cam_op_e;
endpackage

// File: rtl/cam_prio_enc.sv
// Module: cam_prio_enc
// Reduces a request vector to the lowest set index, plus "any" and
// "more than one" flags. Assumes IDX_W bits can hold N-1.
module cam_prio_enc #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any,
    output logic             multi
);
    // Lowest set index wins: scan from the top so the lowest is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Detect one or more, and two or more, requests.
    always_comb begin
        any   = 1'b0;
        multi = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                if (any) multi = 1'b1;
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cam_store.sv
// Module: cam_store
// Entry storage with valid bits and one comparator per entry.
// A write merges data under a keep mask (1 = keep the old bit).
// Assumes at most one write or invalidate per cycle.
module cam_store #(
    parameter int N  = 64,
    parameter int W  = 32,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [W-1:0]  wr_keep,
    input  logic          inv_en,
    input  logic [AW-1:0] inv_addr,
    input  logic          clr_all,
    input  logic [W-1:0]  key,
    input  logic [W-1:0]  key_ignore,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic          rd_valid,
    output logic [N-1:0]  hit_vec,
    output logic [N-1:0]  valid_vec
);
    logic [W-1:0] mem [N];

    // Entry contents: cleared on reset, merged under the keep mask on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= (mem[wr_addr] & wr_keep) | (wr_data & ~wr_keep);
        end
    end

    // Valid bits: set by writes, cleared singly or all at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_vec <= '0;
        end else if (clr_all) begin
            valid_vec <= '0;
        end else if (wr_en) begin
            valid_vec[wr_addr] <= 1'b1;
        end else if (inv_en) begin
            valid_vec[inv_addr] <= 1'b0;
        end
    end

    // One masked comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (((mem[g] ^ key) & ~key_ignore) == '0);
    end

    assign rd_data  = mem[rd_addr];
    assign rd_valid = valid_vec[rd_addr];
endmodule

// File: rtl/cam_ctrl_regs.sv
// Module: cam_ctrl_regs
// Holds the comparand, both masks, the mask selection and the page
// register, and flags commands that must start a search.
// Assumes PAGE_W <= W.
module cam_ctrl_regs
    import cam_pkg::*;
#(
    parameter int W      = 32,
    parameter int PAGE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  cam_op_e           cmd_op,
    input  logic [W-1:0]      cmd_data,
    output logic [W-1:0]      cmp_q,
    output logic [W-1:0]      mask1_q,
    output logic [W-1:0]      mask2_q,
    output logic              sel2_q,
    output logic [PAGE_W-1:0] page_q,
    output logic              search_req
);
    // Register updates from the command port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q   <= '0;
            mask1_q <= '0;
            mask2_q <= '0;
            sel2_q  <= 1'b0;
            page_q  <= '0;
        end else if (cmd_valid) begin
            unique case (cmd_op)
                OP_WR_CMP:    cmp_q   <= cmd_data;
                OP_WR_MASK1:  mask1_q <= cmd_data;
                OP_WR_MASK2:  mask2_q <= cmd_data;
                OP_WR_PAGE:   page_q  <= cmd_data[PAGE_W-1:0];
                OP_SHL_MASK2: mask2_q <= mask2_q << 1;
                OP_SHR_MASK2: mask2_q <= mask2_q >> 1;
                OP_SEL_MASK:  sel2_q  <= cmd_data[0];
                default: ;
            endcase
        end
    end

    // Commands that launch a search on the following cycle.
    always_comb begin
        search_req = 1'b0;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_WR_CMP, OP_WR_MASK1, OP_WR_MASK2,
                OP_WR_PAGE, OP_SEARCH: search_req = 1'b1;
                default: search_req = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/masked_cam.sv
// Module: masked_cam (top)
// Masked associative search array with a priority-encoded status word.
// A search launched by a command is evaluated on the next cycle using
// the register values that command left behind.
module masked_cam
    import cam_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int WIDTH   = 32,
    parameter int PAGE_W  = 16,
    localparam int AW     = $clog2(ENTRIES),
    localparam int STAT_W = PAGE_W + AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [WIDTH-1:0]  cmd_data,
    input  logic [1:0]        rd_sel,
    input  logic [AW-1:0]     rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_valid,
    output logic [AW-1:0]     next_free,
    output logic [STAT_W-1:0] status
);
    cam_op_e           op;
    logic [WIDTH-1:0]  cmp_q, mask1_q, mask2_q, act_mask, ent_data;
    logic              sel2_q, search_req, cmp_pend;
    logic [PAGE_W-1:0] page_q;
    logic [ENTRIES-1:0] hit_vec, valid_vec;
    logic [AW-1:0]     hit_idx, free_idx, wr_addr;
    logic              hit_any, hit_multi, free_any, free_multi;
    logic              wr_en, inv_en, clr_all, fill_ok;
    logic [WIDTH-1:0]  wr_data;

    assign op       = cam_op_e'(cmd_op);
    assign act_mask = sel2_q ? mask2_q : mask1_q;

    cam_ctrl_regs #(.W(WIDTH), .PAGE_W(PAGE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op),
        .cmd_data(cmd_data), .cmp_q(cmp_q), .mask1_q(mask1_q),
        .mask2_q(mask2_q), .sel2_q(sel2_q), .page_q(page_q),
        .search_req(search_req)
    );

    // Entry write path: explicit address, or next free entry when not full.
    assign fill_ok = cmd_valid && (op == OP_FILL_FREE) && free_any;
    assign wr_en   = (cmd_valid && (op == OP_WR_MEM)) || fill_ok;
    assign wr_addr = fill_ok ? free_idx : cmd_addr;
    assign wr_data = fill_ok ? cmp_q : cmd_data;
    assign inv_en  = cmd_valid && (op == OP_INVAL);
    assign clr_all = cmd_valid && (op == OP_CLR_VALID);

    cam_store #(.N(ENTRIES), .W(WIDTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_keep(act_mask), .inv_en(inv_en),
        .inv_addr(cmd_addr), .clr_all(clr_all), .key(cmp_q),
        .key_ignore(act_mask), .rd_addr(rd_addr), .rd_data(ent_data),
        .rd_valid(rd_valid), .hit_vec(hit_vec), .valid_vec(valid_vec)
    );

    cam_prio_enc #(.N(ENTRIES), .IDX_W(AW)) u_hit_enc (
        .req(hit_vec), .idx(hit_idx), .any(hit_any), .multi(hit_multi)
    );

    cam_prio_enc #(.N(ENTRIES), .IDX_W(AW)) u_free_enc (
        .req(~valid_vec), .idx(free_idx), .any(free_any), .multi(free_multi)
    );

    assign next_free = free_any ? free_idx : '0;

    // Read port source selection.
    always_comb begin
        unique case (rd_sel)
            2'd0:    rd_data = ent_data;
            2'd1:    rd_data = cmp_q;
            2'd2:    rd_data = mask1_q;
            default: rd_data = mask2_q;
        endcase
    end

    // Delay the search request one cycle so the written register is used.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_pend <= 1'b0;
        else        cmp_pend <= search_req;
    end

    // Status word capture on a pending search.
    always_ff @(posedge clk) begin
        if (!rst_n)        status <= '0;
        else if (cmp_pend) status <= {page_q, hit_idx, hit_multi, hit_any, ~free_any};
    end
endmodule

// File: rtl/cam_checker.sv
// Module: cam_checker
// Temporal properties of the status word and mask two shifting,
// bound into masked_cam.
module cam_checker #(
    parameter int W      = 32,
    parameter int AW     = 6,
    parameter int PAGE_W = 16,
    localparam int STAT_W = PAGE_W + AW + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [3:0]        cmd_op,
    input logic              cmp_pend,
    input logic [W-1:0]      mask2_q,
    input logic [PAGE_W-1:0] page_q,
    input logic [STAT_W-1:0] status
);
    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> status[1]); // R4
    AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !status[1] |-> (status[3 +: AW] == '0)); // R3
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_pend |=> $stable(status)); // R5
    AST_PAGE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_pend |=> (status[STAT_W-1 -: PAGE_W] == $past(page_q))); // R6
    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd9) |=> (mask2_q == ($past(mask2_q) << 1))); // R8
    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd10) |=> (mask2_q == ($past(mask2_q) >> 1))); // R8
endmodule

bind masked_cam cam_checker #(.W(WIDTH), .AW(AW), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmp_pend(cmp_pend), .mask2_q(mask2_q), .page_q(page_q), .status(status)
);

// File: tb/masked_cam_tb.sv
// Bench for masked_cam: table-driven search sequence, then directed
// tests for masked writes, filling, full behaviour and reset.
module masked_cam_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [5:0]  cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [5:0]  next_free;
    logic [24:0] status;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    masked_cam u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_sel(rd_sel),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .next_free(next_free), .status(status)
    );

    // {op, addr, data, check, expected status}
    localparam int NV = 17;
    localparam logic [67:0] TBL [NV] = '{
        {4'd4,  6'd0,  32'h0000_00A5, 1'b1, 25'h14A00},  // R6 page, no hit
        {4'd5,  6'd5,  32'h1234_5678, 1'b0, 25'h0},
        {4'd5,  6'd9,  32'h1234_5678, 1'b0, 25'h0},
        {4'd5,  6'd20, 32'h1234_FFFF, 1'b0, 25'h0},
        {4'd5,  6'd30, 32'h1234_5679, 1'b0, 25'h0},
        {4'd1,  6'd0,  32'h1234_5678, 1'b1, 25'h14A2E},  // R3 R4 two hits
        {4'd7,  6'd5,  32'h0,         1'b0, 25'h0},
        {4'd8,  6'd0,  32'h0,         1'b1, 25'h14A4A},  // R2 invalid skipped
        {4'd2,  6'd0,  32'h0000_FFFF, 1'b1, 25'h14A4E},  // R1 low half ignored
        {4'd11, 6'd0,  32'h1,         1'b0, 25'h0},
        {4'd8,  6'd0,  32'h0,         1'b1, 25'h14A4A},  // R9 mask two (zero)
        {4'd3,  6'd0,  32'h1,         1'b1, 25'h14A4E},  // R1 bit 0 ignored
        {4'd9,  6'd0,  32'h0,         1'b0, 25'h0},
        {4'd8,  6'd0,  32'h0,         1'b1, 25'h14A4A},  // R8 shifted left
        {4'd10, 6'd0,  32'h0,         1'b0, 25'h0},
        {4'd8,  6'd0,  32'h0,         1'b1, 25'h14A4E},  // R8 shifted right
        {4'd11, 6'd0,  32'h0,         1'b0, 25'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one command; returns 1 ns after the accepting edge.
    task automatic do_cmd(input logic [3:0] op, input logic [5:0] a, input logic [31:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_op = 4'd0;
    endtask

    // Wait for the status load edge after a search command.
    task automatic settle();
        @(posedge clk); #1;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12 reset state
        check("R12", 32'(status), 32'h0);
        check("R10", 32'(next_free), 32'h0);
        rd_sel = 2'd0; rd_addr = 6'd9; #1;
        check("R12", rd_data, 32'h0);
        check("R12", 32'(rd_valid), 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_cmd(TBL[i][67:64], TBL[i][63:58], TBL[i][57:26]);
            settle();
            if (TBL[i][25]) check($sformatf("R5 vec%0d", i), 32'(status), 32'(TBL[i][24:0]));
        end

        // R8 mask two contents visible at the read port
        rd_sel = 2'd3; #1;
        check("R8", rd_data, 32'h1);

        // R7 masked entry write under mask one = 0000FFFF
        do_cmd(4'd5, 6'd9, 32'hABCD_0000);
        rd_sel = 2'd0; rd_addr = 6'd9; #1;
        check("R7", rd_data, 32'hABCD_5678);
        check("R7", 32'(rd_valid), 32'h1);

        // R2 clear all valid bits; R10 next free back to 0
        do_cmd(4'd12, 6'd0, 32'h0);
        #1;
        check("R2", 32'(rd_valid), 32'h0);
        check("R10", 32'(next_free), 32'h0);

        // R11 fill every entry with the comparand
        do_cmd(4'd2, 6'd0, 32'h0);
        do_cmd(4'd1, 6'd0, 32'hCAFE_0001);
        for (int k = 0; k < 64; k++) begin
            if (k == 17) check("R10", 32'(next_free), 32'd17);
            do_cmd(4'd6, 6'd0, 32'h0);
        end
        check("R10", 32'(next_free), 32'h0);
        do_cmd(4'd8, 6'd0, 32'h0);
        settle();
        check("R10", 32'(status), 32'h14A07);

        // R5 comparand write searches; R11 fill ignored when full
        do_cmd(4'd1, 6'd0, 32'h0BAD_F00D);
        settle();
        check("R5", 32'(status), 32'h14A01);
        do_cmd(4'd6, 6'd0, 32'h0);
        do_cmd(4'd8, 6'd0, 32'h0);
        settle();
        check("R11", 32'(status), 32'h14A01);

        // R3 high address after freeing entry 40
        do_cmd(4'd7, 6'd40, 32'h0);
        #1;
        check("R10", 32'(next_free), 32'd40);
        do_cmd(4'd6, 6'd0, 32'h0);
        do_cmd(4'd8, 6'd0, 32'h0);
        settle();
        check("R3", 32'(status), 32'h14B43);

        // R12 reset again clears status and registers
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        check("R12", 32'(status), 32'h0);
        rd_sel = 2'd1; #1;
        check("R12", rd_data, 32'h0);
        rd_sel = 2'd2; #1;
        check("R12", rd_data, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule